// File: doc/BRIEF.md
# Dual-Path Serial Clock Generator

This block produces the serial clock for an SPI master's shift engine from the controller's source clock. Two divider algorithms sit behind a path-select input. The binary path divides the source by four times a power of two. The linear path divides it by two times (N+1). Both paths are reduced to a half-period length in source cycles. A single counter then times each half of the serial-clock period.

While `run` is high the generator alternates between a leading half and a trailing half. It pulses `lead_tick` in the cycle the clock moves to its active level and `trail_tick` in the cycle it returns to idle. The trailing tick also marks the end of a bit period for the shift engine. While stopped, the clock rests at the idle polarity given by `cpol`.

The divider inputs are sampled only at the start of a period, so a setting change never shortens a half-period. Dropping `run` in the active half lets that half finish before the clock stops, so no runt pulse appears on the line.

Top module: `dual_sclk_gen`

## Requirements
- R1: After synchronous reset, `lead_tick` and `trail_tick` are low and `sclk` equals `cpol`.
- R2: With `path_sel` = 0 the serial-clock period is 4·2^N source cycles, N = `pow2_exp` (N = 0, 1, 2, 3 give 4, 8, 16, 32); each half lasts 2^(N+1) cycles.
- R3: With `path_sel` = 1 the serial-clock period is 2·(N+1) source cycles, N = `lin_div`; each half lasts N+1 cycles.
- R4: When `run` is first sampled high at a rising edge, the first `lead_tick` is visible after the H-th rising edge counted from that one, H being the half length. Each period starts with its leading half.
- R5: Each period carries exactly one single-cycle `lead_tick`, which coincides with `sclk` going to `~cpol`, and one single-cycle `trail_tick`, which coincides with `sclk` returning to `cpol`.
- R6: While stopped, no tick is produced and `sclk` follows `cpol`.
- R7: A change of `path_sel`, `pow2_exp` or `lin_div` made during a period has no effect on that period; it applies from the next period on.
- R8: If `run` falls during the active half, that half completes with its `trail_tick`, and then the generator stops.
- R9: If `run` falls during the leading half before `lead_tick`, the generator stops at the next edge and produces no `lead_tick`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | Request to produce serial-clock periods |
| cpol | input | 1 | Idle level of the serial clock |
| path_sel | input | 1 | 0 selects the power-of-two path, 1 the linear path |
| pow2_exp | input | 3 | Exponent N of the power-of-two path |
| lin_div | input | 8 | Divisor N of the linear path |
| sclk | output | 1 | Serial clock |
| lead_tick | output | 1 | One-cycle pulse at the leading clock edge |
| trail_tick | output | 1 | One-cycle pulse at the trailing edge, end of a bit period |

## Verification
The assertions assume that `cpol` changes only while the generator is stopped, and that the divider inputs are valid binary values at every rising edge. They do not assume the divider inputs hold still during a period. The stimulus changes `cpol` only during idle gaps. It changes the divider settings either while stopped or right after a leading tick, so the hold-until-period-start rule is exercised at each of these points. Random bursts cover both paths across their full divisor range, and directed cases cover the smallest and largest ratios and both ways of stopping.

// File: rtl/sclkgen_pkg.sv
// Shared types for the dual-path serial clock generator.
// Assumes nothing beyond being compiled before the modules that import it.
package sclkgen_pkg;

    typedef enum logic {
        PATH_BINARY = 1'b0,
        PATH_LINEAR = 1'b1
    } sclk_path_e;

endpackage

// File: rtl/sclkgen_half.sv
// Half-period calculator: turns the selected divider setting into the
// number of source cycles per serial-clock half.
// Binary path: 2^(N+1). Linear path: N+1.
// Assumes CNT_W is wide enough for the largest result of either path.
module sclkgen_half
    import sclkgen_pkg::*;
#(
    parameter int POW_W = 3,
    parameter int LIN_W = 8,
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  sclk_path_e       path,
    input  logic [POW_W-1:0] pow_n,
    input  logic [LIN_W-1:0] lin_n,
    output logic [CNT_W-1:0] half
);

    logic [POW_W:0]   shift_amt;
    logic [CNT_W-1:0] pow_half;
    logic [CNT_W-1:0] lin_half;

    // Half length of each path, then the select.
    always_comb begin
        shift_amt = {1'b0, pow_n} + {{POW_W{1'b0}}, 1'b1};
        pow_half  = CNT_W'(1) << shift_amt;
        lin_half  = CNT_W'(lin_n) + CNT_W'(1);
        half      = (path == PATH_LINEAR) ? lin_half : pow_half;
    end

    // Every setting must map to at least one cycle per half.
    p_half_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        half != '0);

endmodule

// File: rtl/sclkgen_phase.sv
// Half-period timer and phase tracker. It counts source cycles in each
// half and flips the phase at the end of a half. The flip to the active
// half is reported as a leading tick, the flip back as a trailing tick.
// The half length is taken from half_in only at the start of a period,
// and a stop is honoured only in the leading half.
// Assumes half_in is never zero.
module sclkgen_phase #(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] half_in,
    output logic             phase,
    output logic             lead_tick,
    output logic             trail_tick
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] half_q;
    logic             phase_q;
    logic             lead_q;
    logic             trail_q;

    logic             at_start;
    logic [CNT_W-1:0] half_eff;
    logic             stop_now;
    logic             half_done;

    // Period start picks up new settings; otherwise keep the held length.
    always_comb begin
        at_start  = (cnt_q == '0) && !phase_q;
        half_eff  = at_start ? half_in : half_q;
        stop_now  = !run && !phase_q;
        half_done = (cnt_q == half_eff - CNT_W'(1));
    end

    // Advance the counter, flip the phase and pulse the tick at a half end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            half_q  <= CNT_W'(1);
            phase_q <= 1'b0;
            lead_q  <= 1'b0;
            trail_q <= 1'b0;
        end else if (stop_now) begin
            cnt_q   <= '0;
            half_q  <= half_in;
            phase_q <= 1'b0;
            lead_q  <= 1'b0;
            trail_q <= 1'b0;
        end else begin
            half_q  <= half_eff;
            lead_q  <= 1'b0;
            trail_q <= 1'b0;
            if (half_done) begin
                cnt_q   <= '0;
                phase_q <= !phase_q;
                lead_q  <= !phase_q;
                trail_q <= phase_q;
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    assign phase      = phase_q;
    assign lead_tick  = lead_q;
    assign trail_tick = trail_q;

    // Each tick lasts a single cycle.
    p_lead_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        lead_q |=> !lead_q);
    p_trail_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        trail_q |=> !trail_q);

    // The counter never passes the held half length.
    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < half_q);

    // The held half length does not move inside the active half.
    p_half_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        phase_q |=> $stable(half_q));

    // Stopped in the leading half means no leading tick follows.
    p_idle_nolead_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !phase_q) |=> !lead_q);

    // The active half always ends with a trailing tick, even with run low.
    p_finish_trail_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(phase_q) |-> trail_q);

endmodule

// File: rtl/dual_sclk_gen.sv
// Dual-path serial clock generator top. It picks a half-period length
// from the binary or linear divider path, times the halves and drives
// the serial clock at cpol XOR the current phase.
// Assumes cpol changes only while the generator is stopped.
module dual_sclk_gen
    import sclkgen_pkg::*;
#(
    parameter int POW_W = 3,
    parameter int LIN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             cpol,
    input  logic             path_sel,
    input  logic [POW_W-1:0] pow2_exp,
    input  logic [LIN_W-1:0] lin_div,
    output logic             sclk,
    output logic             lead_tick,
    output logic             trail_tick
);

    localparam int POW_MAX_LOG = 2 ** POW_W;
    localparam int CNT_W = ((POW_MAX_LOG > LIN_W) ? POW_MAX_LOG : LIN_W) + 1;

    logic [CNT_W-1:0] half_len;
    logic             phase;
    sclk_path_e       path;

    assign path = sclk_path_e'(path_sel);

    sclkgen_half #(
        .POW_W (POW_W),
        .LIN_W (LIN_W),
        .CNT_W (CNT_W)
    ) u_half (
        .clk   (clk),
        .rst_n (rst_n),
        .path  (path),
        .pow_n (pow2_exp),
        .lin_n (lin_div),
        .half  (half_len)
    );

    sclkgen_phase #(
        .CNT_W (CNT_W)
    ) u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .half_in    (half_len),
        .phase      (phase),
        .lead_tick  (lead_tick),
        .trail_tick (trail_tick)
    );

    // The line level is the idle polarity, inverted in the active half.
    assign sclk = cpol ^ phase;

    // A leading tick leaves the line at the active level.
    p_lead_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
        lead_tick |-> (sclk != cpol));

endmodule

// File: tb/dual_sclk_gen_bench.sv
module dual_sclk_gen_bench;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       run;
    logic       cpol;
    logic       path_sel;
    logic [2:0] pow2_exp;
    logic [7:0] lin_div;
    logic       sclk;
    logic       lead_tick;
    logic       trail_tick;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    dual_sclk_gen u_dual_sclk_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .cpol       (cpol),
        .path_sel   (path_sel),
        .pow2_exp   (pow2_exp),
        .lin_div    (lin_div),
        .sclk       (sclk),
        .lead_tick  (lead_tick),
        .trail_tick (trail_tick)
    );

    // Expected half length from the requirements (R2, R3).
    function automatic int half_of(bit sel, int n);
        if (sel) return n + 1;
        return 1 << ((n % 8) + 1);
    endfunction

    // One check of {lead, trail, sclk} against the expectation.
    task automatic chk(string req, logic [2:0] act, logic [2:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: {lead,trail,sclk} actual %b expected %b at %0t",
                     req, act, exp, $time);
        end
    endtask

    task automatic set_div(bit sel, int n);
        path_sel = sel;
        pow2_exp = 3'(n % 8);
        lin_div  = 8'(n);
    endtask

    // Check one half of h cycles: the tick and the level change on its last cycle.
    task automatic check_half(int h, bit lead_half, bit cp, string req);
        for (int t = 1; t <= h; t++) begin
            logic [2:0] exp;
            @(negedge clk);
            if (t == h) exp = lead_half ? {2'b10, ~cp} : {2'b01, cp};
            else        exp = lead_half ? {2'b00, cp}  : {2'b00, ~cp};
            chk(req, {lead_tick, trail_tick, sclk}, exp);
        end
    endtask

    // Stopped: no ticks and the line at cpol (R6).
    task automatic check_idle(int n, bit cp, string req);
        for (int t = 0; t < n; t++) begin
            @(negedge clk);
            chk(req, {lead_tick, trail_tick, sclk}, {2'b00, cp});
        end
    endtask

    // Full burst of whole periods; run drops right after the last trailing tick.
    task automatic burst(bit sel, int n, bit cp, int periods, string req);
        int h;
        h = half_of(sel, n);
        set_div(sel, n);
        cpol = cp;
        run  = 1'b1;
        for (int p = 0; p < periods; p++) begin
            check_half(h, 1'b1, cp, req);
            check_half(h, 1'b0, cp, req);
        end
        run = 1'b0;
        check_idle(3, cp, "R6 idle after burst");
    endtask

    initial begin
        void'($urandom(32'h5EED_C10C));
        rst_n = 1'b0;
        run   = 1'b0;
        cpol  = 1'b0;
        set_div(1'b0, 0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1 reset state", {lead_tick, trail_tick, sclk}, 3'b000);
        check_idle(2, 1'b0, "R1 reset state");

        // R6: the line follows cpol while stopped.
        cpol = 1'b1;
        check_idle(2, 1'b1, "R6 cpol follow");
        cpol = 1'b0;
        check_idle(2, 1'b0, "R6 cpol follow");

        // R2: binary ratios 4, 8, 16, 32 and the largest one.
        for (int n = 0; n < 4; n++) burst(1'b0, n, n[0], 2, "R2 binary ratio");
        burst(1'b0, 7, 1'b1, 1, "R2 binary max");

        // R3: smallest and largest linear ratios, and R4 latency with both.
        burst(1'b1, 0, 1'b0, 3, "R3 linear div2");
        burst(1'b1, 0, 1'b1, 2, "R4 first lead latency");
        burst(1'b1, 255, 1'b0, 1, "R3 linear max");
        burst(1'b1, 4, 1'b1, 2, "R5 tick per period");

        // R7: change settings right after a leading tick.
        begin
            int h1, h2;
            h1 = half_of(1'b1, 5);
            h2 = half_of(1'b0, 2);
            set_div(1'b1, 5);
            cpol = 1'b0;
            run  = 1'b1;
            check_half(h1, 1'b1, 1'b0, "R7 old period lead");
            set_div(1'b0, 2);
            check_half(h1, 1'b0, 1'b0, "R7 old period kept");
            check_half(h2, 1'b1, 1'b0, "R7 new period lead");
            check_half(h2, 1'b0, 1'b0, "R7 new period trail");
            run = 1'b0;
            check_idle(3, 1'b0, "R6 idle after R7");
        end

        // R8: run drops in the active half; the trailing half completes.
        begin
            int h;
            h = half_of(1'b1, 6);
            set_div(1'b1, 6);
            cpol = 1'b1;
            run  = 1'b1;
            check_half(h, 1'b1, 1'b1, "R8 lead before stop");
            run = 1'b0;
            check_half(h, 1'b0, 1'b1, "R8 trail completes");
            check_idle(2 * h + 2, 1'b1, "R8 stopped after trail");
        end

        // R9: run drops in the leading half; no leading tick appears.
        begin
            int h;
            h = half_of(1'b0, 2);
            set_div(1'b0, 2);
            cpol = 1'b0;
            run  = 1'b1;
            repeat (h / 2) begin
                @(negedge clk);
                chk("R9 before stop", {lead_tick, trail_tick, sclk}, 3'b000);
            end
            run = 1'b0;
            check_idle(2 * h + 2, 1'b0, "R9 no lead after early stop");
        end

        // Random bursts over both paths.
        for (int i = 0; i < 40; i++) begin
            bit sel;
            int n;
            sel = 1'($urandom % 2);
            n   = sel ? int'($urandom % 256) : int'($urandom % 8);
            burst(sel, n, 1'($urandom % 2), 1 + int'($urandom % 2),
                  sel ? "R3 random linear" : "R2 random binary");
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule